// File: doc/BRIEF.md
# Store Address Generation Unit

This block turns one decoded store request into the effective memory address, an optional new pointer value, a store strobe and, for the lock-conditional form, an update for the zero flag. The decoder supplies the access size, the addressing mode, the pointer and index register values, a 2-bit shift amount, the raw displacement field, a condition-passed flag and the current lock flag. The register file, the condition logic and the memory port take the registered results one cycle later.

How the displacement is treated depends on the addressing mode and the access size. It can be zero- or sign-extended, taken from 3, 4, 7, 8, 9 or 16 bits, and scaled by 1, 2 or 4. Auto-modify modes step the pointer by the access size. Predicated stores occupy the unit for two cycles, and the unit reports this through `busy_o`.

Top module: `store_agu`

## Requirements
- R1: While `rst_n` is low, `out_vld_o`, `ptr_we_o`, `st_en_o`, `zf_we_o` and `busy_o` are 0.
- R2: A request is accepted when `req_vld_i` is 1 and `busy_o` is 0. Its results appear on the outputs one clock later, with `out_vld_o` = 1. `ptr_we_o` is 1 only for modes 0 and 1.
- R3: Mode 0 (post-increment) gives `addr_o` = pointer and `ptr_new_o` = pointer + step. The step is 1, 2, 4 or 8 for `size_i` codes 0 (byte), 1 (halfword), 2 (word) and 3 (doubleword).
- R4: Mode 1 (pre-decrement) gives `addr_o` = `ptr_new_o` = pointer − step.
- R5: Mode 2 (short displacement) adds a zero-extended offset: disp[2:0] for a byte, disp[2:0]<<1 for a halfword, disp[3:0]<<2 for a word, and 0 for a doubleword.
- R6: Mode 3 (long displacement) adds disp[15:0], sign-extended and unscaled, for every size.
- R7: Mode 4 (indexed) gives `addr_o` = pointer + (index << `shamt_i`).
- R8: Mode 5 (predicated) adds disp[8:0] as follows: sign-extended for a byte, sign-extended then <<1 for a halfword, and zero-extended then <<2 for a word or doubleword. `st_en_o` equals `cond_ok_i`.
- R9: After a mode-5 request is accepted, `busy_o` is 1 for exactly one cycle. A request presented during that cycle is ignored and produces no output.
- R10: Mode 6 (stack-relative) gives `addr_o` = (pointer with bits [1:0] cleared) + (zero-extended disp[6:0] << 2).
- R11: Mode 7 (lock-conditional) gives `addr_o` = pointer + sign-extended disp[15:0], with `zf_we_o` = 1 and `zf_val_o` = `st_en_o` = `lock_i`.
- R12: Mode 8 (halfword-combine) adds zero-extended disp[7:0] << 2.
- R13: All address and pointer arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | Store request present |
| size_i | input | 2 | Access size code |
| mode_i | input | 4 | Addressing mode code |
| ptr_i | input | 32 | Pointer / base register value |
| idx_i | input | 32 | Index register value |
| shamt_i | input | 2 | Index shift amount |
| disp_i | input | 16 | Raw displacement field |
| cond_ok_i | input | 1 | Predicate condition passed |
| lock_i | input | 1 | Current lock flag |
| out_vld_o | output | 1 | Result valid |
| addr_o | output | 32 | Effective store address |
| ptr_we_o | output | 1 | Pointer writeback enable |
| ptr_new_o | output | 32 | New pointer value |
| st_en_o | output | 1 | Store enable |
| zf_we_o | output | 1 | Zero-flag write enable |
| zf_val_o | output | 1 | Zero-flag new value |
| busy_o | output | 1 | Second cycle of a predicated store |

## Verification
The bench sets the displacement's top bits so that extension and scaling errors show up. A design that zero-extends where it should sign-extend lands 64 KiB or 512 bytes away. A design that uses the sign-extended 9-bit field for a predicated word moves the address backwards instead of forwards. The bench also checks stepping past zero in both directions, the low-bit mask on the stack pointer, and the lock store with the flag clear. A missing mask gives an unaligned address, and a lock store with the flag clear that still writes memory shows up on `st_en_o`. A request issued during the busy cycle must vanish, and a design that accepts it shows a spurious valid result.

// File: rtl/store_agu_pkg.sv
package store_agu_pkg;

    localparam int unsigned AW     = 32;
    localparam int unsigned DISP_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DWRD = 2'd3
    } size_e;

    typedef enum logic [3:0] {
        M_POSTINC = 4'd0,
        M_PREDEC  = 4'd1,
        M_SHORT   = 4'd2,
        M_LONG    = 4'd3,
        M_INDEX   = 4'd4,
        M_PRED    = 4'd5,
        M_STACK   = 4'd6,
        M_LOCK    = 4'd7,
        M_COMBINE = 4'd8
    } mode_e;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic          ptr_we;
        logic [AW-1:0] ptr_new;
        logic          st_en;
        logic          zf_we;
        logic          zf_val;
        logic          busy;
    } agu_state_t;

endpackage

// File: rtl/store_agu_step.sv
module store_agu_step
    import store_agu_pkg::*;
#(
    parameter int unsigned W = AW
) (
    input  logic [1:0]   size_i,
    output logic [W-1:0] step_o
);
    // step is the access size in bytes: 1 << size code
    always_comb begin
        step_o = W'(1) << size_i;
    end
endmodule

// File: rtl/store_agu_offset.sv
module store_agu_offset
    import store_agu_pkg::*;
#(
    parameter int unsigned W  = AW,
    parameter int unsigned DW = DISP_W
) (
    input  mode_e         mode_i,
    input  size_e         size_i,
    input  logic [DW-1:0] disp_i,
    input  logic [W-1:0]  idx_i,
    input  logic [1:0]    shamt_i,
    output logic [W-1:0]  off_o
);
    logic [W-1:0] z3, z4, z7, z8, z9, s9, s16;

    always_comb begin
        z3  = W'(disp_i[2:0]);
        z4  = W'(disp_i[3:0]);
        z7  = W'(disp_i[6:0]);
        z8  = W'(disp_i[7:0]);
        z9  = W'(disp_i[8:0]);
        s9  = W'($signed(disp_i[8:0]));
        s16 = W'($signed(disp_i[15:0]));

        off_o = '0;
        unique case (mode_i)
            M_SHORT: begin
                unique case (size_i)
                    SZ_BYTE: off_o = z3;
                    SZ_HALF: off_o = z3 << 1;
                    SZ_WORD: off_o = z4 << 2;
                    default: off_o = '0;
                endcase
            end
            M_LONG, M_LOCK: off_o = s16;
            M_INDEX:        off_o = idx_i << shamt_i;
            M_PRED: begin
                unique case (size_i)
                    SZ_BYTE: off_o = s9;
                    SZ_HALF: off_o = s9 << 1;
                    default: off_o = z9 << 2;
                endcase
            end
            M_STACK:   off_o = z7 << 2;
            M_COMBINE: off_o = z8 << 2;
            default:   off_o = '0;
        endcase
    end
endmodule

// File: rtl/store_agu.sv
module store_agu
    import store_agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_vld_i,
    input  logic [1:0]  size_i,
    input  logic [3:0]  mode_i,
    input  logic [31:0] ptr_i,
    input  logic [31:0] idx_i,
    input  logic [1:0]  shamt_i,
    input  logic [15:0] disp_i,
    input  logic        cond_ok_i,
    input  logic        lock_i,
    output logic        out_vld_o,
    output logic [31:0] addr_o,
    output logic        ptr_we_o,
    output logic [31:0] ptr_new_o,
    output logic        st_en_o,
    output logic        zf_we_o,
    output logic        zf_val_o,
    output logic        busy_o
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

    agu_state_t   st_d, st_q;
    mode_e        mode;
    size_e        size;
    logic [AW-1:0] step, off, base, sum;
    logic          accept;

    assign mode = mode_e'(mode_i);
    assign size = size_e'(size_i);

    store_agu_step #(.W(AW)) u_step (
        .size_i (size_i),
        .step_o (step)
    );

    store_agu_offset #(.W(AW), .DW(DISP_W)) u_off (
        .mode_i  (mode),
        .size_i  (size),
        .disp_i  (disp_i),
        .idx_i   (idx_i),
        .shamt_i (shamt_i),
        .off_o   (off)
    );

    always_comb begin
        accept = req_vld_i && !st_q.busy;
        base   = (mode == M_STACK) ? (ptr_i & ALIGN_MASK) : ptr_i;
        sum    = base + off;

        st_d        = st_q;
        st_d.vld    = accept;
        st_d.ptr_we = 1'b0;
        st_d.st_en  = 1'b0;
        st_d.zf_we  = 1'b0;
        st_d.busy   = 1'b0;

        if (accept) begin
            unique case (mode)
                M_POSTINC: begin
                    st_d.addr    = ptr_i;
                    st_d.ptr_new = ptr_i + step;
                    st_d.ptr_we  = 1'b1;
                    st_d.st_en   = 1'b1;
                end
                M_PREDEC: begin
                    st_d.addr    = ptr_i - step;
                    st_d.ptr_new = ptr_i - step;
                    st_d.ptr_we  = 1'b1;
                    st_d.st_en   = 1'b1;
                end
                M_SHORT, M_LONG, M_INDEX, M_STACK, M_COMBINE: begin
                    st_d.addr  = sum;
                    st_d.st_en = 1'b1;
                end
                M_PRED: begin
                    st_d.addr  = sum;
                    st_d.st_en = cond_ok_i;
                    st_d.busy  = 1'b1;
                end
                M_LOCK: begin
                    st_d.addr   = sum;
                    st_d.st_en  = lock_i;
                    st_d.zf_we  = 1'b1;
                    st_d.zf_val = lock_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld_o = st_q.vld;
    assign addr_o    = st_q.addr;
    assign ptr_we_o  = st_q.ptr_we;
    assign ptr_new_o = st_q.ptr_new;
    assign st_en_o   = st_q.st_en;
    assign zf_we_o   = st_q.zf_we;
    assign zf_val_o  = st_q.zf_val;
    assign busy_o    = st_q.busy;
endmodule

// File: rtl/store_agu_chk.sv
module store_agu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld_i,
    input logic [1:0]  size_i,
    input logic [3:0]  mode_i,
    input logic [31:0] ptr_i,
    input logic [31:0] idx_i,
    input logic [1:0]  shamt_i,
    input logic [15:0] disp_i,
    input logic        cond_ok_i,
    input logic        lock_i,
    input logic        out_vld_o,
    input logic [31:0] addr_o,
    input logic        ptr_we_o,
    input logic [31:0] ptr_new_o,
    input logic        st_en_o,
    input logic        zf_we_o,
    input logic        zf_val_o,
    input logic        busy_o
);
    logic took;
    assign took = req_vld_i && !busy_o;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !(ptr_we_o || st_en_o || zf_we_o || busy_o || out_vld_o));

    // R2
    ptr_we_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we_o |-> out_vld_o);

    // R3
    postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && mode_i == 4'd0) |=>
            (addr_o == $past(ptr_i) && ptr_new_o == addr_o + (32'd1 << $past(size_i))));

    // R4
    predec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && mode_i == 4'd1) |=> (ptr_we_o && ptr_new_o == addr_o));

    // R9
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);

    // R9
    busy_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !out_vld_o);

    // R11
    lock_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zf_we_o |-> (st_en_o == zf_val_o));

    // R10
    stack_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && mode_i == 4'd6) |=> (addr_o[1:0] == 2'b00));
endmodule

bind store_agu store_agu_chk u_chk (.*);

// File: tb/tb_store_agu.sv
module tb_store_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic [3:0]  mode_i = '0;
    logic [31:0] ptr_i = '0;
    logic [31:0] idx_i = '0;
    logic [1:0]  shamt_i = '0;
    logic [15:0] disp_i = '0;
    logic        cond_ok_i = 1'b0;
    logic        lock_i = 1'b0;
    logic        out_vld_o, ptr_we_o, st_en_o, zf_we_o, zf_val_o, busy_o;
    logic [31:0] addr_o, ptr_new_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    store_agu dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // drive one request for one cycle; return at the negedge where results are visible
    task automatic send(input logic [3:0] m, input logic [1:0] s, input logic [31:0] p,
                        input logic [31:0] ix, input logic [1:0] sh, input logic [15:0] d,
                        input logic c, input logic lk);
        @(negedge clk);
        req_vld_i = 1'b1; mode_i = m; size_i = s; ptr_i = p; idx_i = ix;
        shamt_i = sh; disp_i = d; cond_ok_i = c; lock_i = lk;
        @(negedge clk);
        req_vld_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 vld", 32'(out_vld_o), 0);
        chk("R1 ptr_we", 32'(ptr_we_o), 0);
        chk("R1 st_en", 32'(st_en_o), 0);
        chk("R1 zf_we", 32'(zf_we_o), 0);
        chk("R1 busy", 32'(busy_o), 0);
    endtask

    task automatic t_postinc;
        send(4'd0, 2'd3, 32'h0000_1000, 0, 0, 0, 0, 0);
        chk("R2 vld", 32'(out_vld_o), 1);
        chk("R3 addr", addr_o, 32'h0000_1000);
        chk("R3 new dword", ptr_new_o, 32'h0000_1008);
        chk("R2 ptr_we", 32'(ptr_we_o), 1);
        send(4'd0, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        chk("R13 postinc wrap", ptr_new_o, 32'h0000_0000);
        send(4'd0, 2'd1, 32'h0000_0010, 0, 0, 0, 0, 0);
        chk("R3 new half", ptr_new_o, 32'h0000_0012);
    endtask

    task automatic t_predec;
        send(4'd1, 2'd2, 32'h0000_2000, 0, 0, 0, 0, 0);
        chk("R4 addr", addr_o, 32'h0000_1FFC);
        chk("R4 new", ptr_new_o, 32'h0000_1FFC);
        send(4'd1, 2'd1, 32'h0000_0000, 0, 0, 0, 0, 0);
        chk("R13 predec wrap", addr_o, 32'hFFFF_FFFE);
    endtask

    task automatic t_short;
        send(4'd2, 2'd0, 32'h100, 0, 0, 16'hFFFF, 0, 0);
        chk("R5 byte", addr_o, 32'h107);
        chk("R2 no ptr_we", 32'(ptr_we_o), 0);
        send(4'd2, 2'd1, 32'h100, 0, 0, 16'h0005, 0, 0);
        chk("R5 half", addr_o, 32'h10A);
        send(4'd2, 2'd2, 32'h100, 0, 0, 16'h00FF, 0, 0);
        chk("R5 word", addr_o, 32'h13C);
        send(4'd2, 2'd3, 32'h100, 0, 0, 16'h0007, 0, 0);
        chk("R5 dword", addr_o, 32'h100);
    endtask

    task automatic t_long;
        send(4'd3, 2'd2, 32'h0001_0000, 0, 0, 16'h8000, 0, 0);
        chk("R6 negative", addr_o, 32'h0000_8000);
        send(4'd3, 2'd1, 32'h0001_0000, 0, 0, 16'h0011, 0, 0);
        chk("R6 positive unscaled", addr_o, 32'h0001_0011);
    endtask

    task automatic t_index;
        send(4'd4, 2'd2, 32'h100, 32'h3, 2'd2, 0, 0, 0);
        chk("R7 sh2", addr_o, 32'h10C);
        send(4'd4, 2'd0, 32'h100, 32'h5, 2'd0, 0, 0, 0);
        chk("R7 sh0", addr_o, 32'h105);
    endtask

    task automatic t_pred;
        send(4'd5, 2'd0, 32'h1000, 0, 0, 16'h01FF, 1, 0);
        chk("R8 byte", addr_o, 32'h0FFF);
        chk("R8 st_en", 32'(st_en_o), 1);
        chk("R9 busy", 32'(busy_o), 1);
        send(4'd5, 2'd1, 32'h1000, 0, 0, 16'h0100, 1, 0);
        chk("R8 half", addr_o, 32'h0E00);
        send(4'd5, 2'd2, 32'h1000, 0, 0, 16'h01FF, 0, 0);
        chk("R8 word", addr_o, 32'h17FC);
        chk("R8 cond false st_en", 32'(st_en_o), 0);
        chk("R8 cond false ptr_we", 32'(ptr_we_o), 0);
        chk("R8 cond false busy", 32'(busy_o), 1);
    endtask

    task automatic t_busy;
        send(4'd5, 2'd2, 32'h40, 0, 0, 16'h0001, 1, 0);
        chk("R9 busy set", 32'(busy_o), 1);
        req_vld_i = 1'b1; mode_i = 4'd0; size_i = 2'd2; ptr_i = 32'h500;
        @(negedge clk);
        chk("R9 dropped vld", 32'(out_vld_o), 0);
        chk("R9 dropped ptr_we", 32'(ptr_we_o), 0);
        chk("R9 busy cleared", 32'(busy_o), 0);
        @(negedge clk);
        req_vld_i = 1'b0;
        chk("R9 accepted after", 32'(out_vld_o), 1);
        chk("R9 accepted addr", addr_o, 32'h500);
    endtask

    task automatic t_stack;
        send(4'd6, 2'd2, 32'h0000_1003, 0, 0, 16'h007F, 0, 0);
        chk("R10 masked", addr_o, 32'h0000_11FC);
        send(4'd6, 2'd2, 32'h0000_2002, 0, 0, 16'hFF80, 0, 0);
        chk("R10 field width", addr_o, 32'h0000_2000);
    endtask

    task automatic t_lock;
        send(4'd7, 2'd2, 32'h3000, 0, 0, 16'hFFFC, 0, 1);
        chk("R11 addr", addr_o, 32'h2FFC);
        chk("R11 st_en set", 32'(st_en_o), 1);
        chk("R11 zf_we", 32'(zf_we_o), 1);
        chk("R11 zf_val set", 32'(zf_val_o), 1);
        send(4'd7, 2'd2, 32'h3000, 0, 0, 16'h0004, 0, 0);
        chk("R11 st_en clear", 32'(st_en_o), 0);
        chk("R11 zf_val clear", 32'(zf_val_o), 0);
        chk("R11 zf_we clear", 32'(zf_we_o), 1);
    endtask

    task automatic t_combine;
        send(4'd8, 2'd2, 32'h0, 0, 0, 16'hFFFF, 0, 0);
        chk("R12 disp8", addr_o, 32'h3FC);
        chk("R12 st_en", 32'(st_en_o), 1);
        send(4'd8, 2'd2, 32'hFFFF_FFF0, 0, 0, 16'h0008, 0, 0);
        chk("R13 combine wrap", addr_o, 32'h0000_0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_postinc();
        t_predec();
        t_short();
        t_long();
        t_index();
        t_pred();
        t_busy();
        t_stack();
        t_lock();
        t_combine();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule